// File: doc/BRIEF.md
# Daisy-Chain Configuration Bitstream Receiver

This block sits at the serial configuration input of one device in a chain of devices that all share one configuration clock. It watches the incoming serial stream for a fixed 12-bit sync pattern. It then takes in a 24-bit count of the configuration clocks the whole chain needs, and loads its own configuration frames into local storage, one frame-write strobe per frame. While it looks for the sync pattern and takes in the count, it copies every bit to its serial output, so the next device in the chain sees the same header.

While the block loads its own frames, the serial output stays high. Once the last local frame is stored, every further bit goes through to the next device. The block counts every configuration clock from the first sync bit onward. When its storage is full and that count equals the received length, it raises a start signal. Every device in the chain reaches the same count on the same clock, so they all start together. A synchronous clear returns the block to the sync search.

Top module: `chain_cfg_rx`

## Requirements
- R1: While `clr` is high at a rising edge, the block returns to the sync search. From the next rising edge `start` and `frameWr` are 0, and `dout` is 1 from the next falling edge.
- R2: The sync pattern is 12'b111111110010, received leftmost bit first. Any number of leading 1 bits may come before it. Every bit up to and including the last sync bit is copied to `dout`.
- R3: The 24 bits that follow the sync pattern are the length, most significant bit first. They are copied to `dout` unchanged.
- R4: Each `din` bit is sampled on the rising edge of `clk`. The matching `dout` value appears at the next falling edge.
- R5: `dout` is 1 for every bit taken into the block's own frames.
- R6: After the length, every FRAME_BITS bits form one frame. The first bit received goes in the MSB of `frameData`. For each frame, `frameWr` is high for one cycle after the edge that samples the frame's last bit. `frameAddr` counts 0 to NUM_FRAMES-1 in order.
- R7: After NUM_FRAMES frames, each further bit is copied to `dout` while the clock count differs from the length.
- R8: The clock count is 12 when the last sync bit is sampled and rises by 1 for each bit consumed after it. At the first rising edge where storage is full and the count equals the length, `start` goes to 1 and that edge's `din` bit is not consumed.
- R9: Once `start` is 1, it stays 1 until a clear. While it is 1, `dout` is 1 and `frameWr` stays 0.
- R10: A 12-bit pattern that differs from the sync pattern causes no capture. Later bits are still copied to `dout` and no frame is written.
- R11: A clear in the middle of a stream drops the partial load. The next full stream is then received correctly from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edge samples, falling edge drives |
| clr | input | 1 | Synchronous clear, active high |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device in the chain |
| frameWr | output | 1 | One-cycle strobe: a completed frame is on frameData |
| frameData | output | FRAME_BITS | Completed frame, first received bit in the MSB |
| frameAddr | output | $clog2(NUM_FRAMES) | Index of the frame being written |
| start | output | 1 | Configuration complete; chain start-up |

## Verification
The checker assumes that `clr` is held high for at least one rising edge before any activity counts. It also assumes that `din` changes only away from the rising edge, so each sampled bit is well defined. The bench drives `din` one nanosecond after each rising edge and holds `clr` for two edges before every stream. Each bench length value is at least the block's header plus its own frames, so the count compare is always reachable. The checker treats frame writes as counted from the last clear. Every stream, including the one cut short by a mid-stream clear, therefore begins after a clear.

// File: rtl/chain_cfg_pkg.sv
package chain_cfg_pkg;

  localparam int PRE_W = 12;
  localparam logic [PRE_W-1:0] PRE_PATTERN = 12'b1111_1111_0010;
  localparam int LEN_W = 24;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_LOAD,
    ST_FWD,
    ST_DONE
  } cfgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftPre;
    logic loadCnt;
    logic incCnt;
    logic shiftLen;
    logic shiftFrame;
    logic writeFrame;
    logic passDin;
  } cfgStrobe_t;

endpackage

// File: rtl/chain_cfg_ctrl.sv
module chain_cfg_ctrl
  import chain_cfg_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          preMatch,
  input  logic          cntMatch,
  output cfgStrobe_t    strb,
  output logic [AW-1:0] frameIdx,
  output logic          start
);

  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int LW = $clog2(LEN_W);

  cfgState_t       state, nxt;
  logic [LW-1:0]   lenIdx;
  logic [BW-1:0]   bitIdx;
  logic            lastLen, lastBit, lastFrame;

  assign lastLen   = (lenIdx == LW'(LEN_W - 1));
  assign lastBit   = (bitIdx == BW'(FRAME_BITS - 1));
  assign lastFrame = (frameIdx == AW'(NUM_FRAMES - 1));
  assign start     = (state == ST_DONE);

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_HUNT: begin
        strb.shiftPre = 1'b1;
        strb.passDin  = 1'b1;
        if (preMatch) begin
          strb.loadCnt = 1'b1;
          nxt          = ST_LEN;
        end
      end
      ST_LEN: begin
        strb.shiftLen = 1'b1;
        strb.incCnt   = 1'b1;
        strb.passDin  = 1'b1;
        if (lastLen) nxt = ST_LOAD;
      end
      ST_LOAD: begin
        strb.shiftFrame = 1'b1;
        strb.incCnt     = 1'b1;
        if (lastBit) begin
          strb.writeFrame = 1'b1;
          if (lastFrame) nxt = ST_FWD;
        end
      end
      ST_FWD: begin
        if (cntMatch) begin
          nxt = ST_DONE;
        end else begin
          strb.incCnt  = 1'b1;
          strb.passDin = 1'b1;
        end
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= ST_HUNT;
      lenIdx   <= '0;
      bitIdx   <= '0;
      frameIdx <= '0;
    end else begin
      state <= nxt;
      if (strb.shiftLen)
        lenIdx <= lastLen ? '0 : lenIdx + LW'(1);
      if (strb.shiftFrame)
        bitIdx <= lastBit ? '0 : bitIdx + BW'(1);
      if (strb.writeFrame && !lastFrame)
        frameIdx <= frameIdx + AW'(1);
    end
  end

endmodule

// File: rtl/chain_cfg_dp.sv
module chain_cfg_dp
  import chain_cfg_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int AW = 2
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  din,
  input  cfgStrobe_t            strb,
  input  logic [AW-1:0]         frameIdx,
  output logic                  preMatch,
  output logic                  cntMatch,
  output logic                  dout,
  output logic                  frameWr,
  output logic [FRAME_BITS-1:0] frameData,
  output logic [AW-1:0]         frameAddr
);

  logic [PRE_W-2:0]      preReg;
  logic [LEN_W-1:0]      lenReg;
  logic [LEN_W-1:0]      clkCnt;
  logic [FRAME_BITS-2:0] frameShift;
  logic                  outBit;

  assign preMatch = ({preReg, din} == PRE_PATTERN);
  assign cntMatch = (clkCnt == lenReg);

  always_ff @(posedge clk) begin
    if (clr) begin
      preReg     <= '0;
      lenReg     <= '0;
      clkCnt     <= '0;
      frameShift <= '0;
      outBit     <= 1'b1;
      frameWr    <= 1'b0;
      frameData  <= '0;
      frameAddr  <= '0;
    end else begin
      outBit  <= strb.passDin ? din : 1'b1;
      frameWr <= strb.writeFrame;
      if (strb.shiftPre)
        preReg <= (PRE_W-1)'({preReg, din});
      if (strb.shiftLen)
        lenReg <= {lenReg[LEN_W-2:0], din};
      if (strb.loadCnt)
        clkCnt <= LEN_W'(PRE_W);
      else if (strb.incCnt)
        clkCnt <= clkCnt + LEN_W'(1);
      if (strb.shiftFrame)
        frameShift <= (FRAME_BITS-1)'({frameShift, din});
      if (strb.writeFrame) begin
        frameData <= {frameShift, din};
        frameAddr <= frameIdx;
      end
    end
  end

  // downstream data changes on the falling edge
  always_ff @(negedge clk) begin
    dout <= outBit;
  end

endmodule

// File: rtl/chain_cfg_rx.sv
module chain_cfg_rx
  import chain_cfg_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  din,
  output logic                  dout,
  output logic                  frameWr,
  output logic [FRAME_BITS-1:0] frameData,
  output logic [AW-1:0]         frameAddr,
  output logic                  start
);

  cfgStrobe_t    strb;
  logic [AW-1:0] frameIdx;
  logic          preMatch, cntMatch;

  chain_cfg_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .NUM_FRAMES(NUM_FRAMES),
    .AW(AW)
  ) u_ctrl (
    .clk(clk), .clr(clr), .preMatch(preMatch), .cntMatch(cntMatch),
    .strb(strb), .frameIdx(frameIdx), .start(start)
  );

  chain_cfg_dp #(
    .FRAME_BITS(FRAME_BITS),
    .AW(AW)
  ) u_dp (
    .clk(clk), .clr(clr), .din(din), .strb(strb), .frameIdx(frameIdx),
    .preMatch(preMatch), .cntMatch(cntMatch), .dout(dout),
    .frameWr(frameWr), .frameData(frameData), .frameAddr(frameAddr)
  );

endmodule

// File: rtl/chain_cfg_rx_chk.sv
module chain_cfg_rx_chk #(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic          clk,
  input logic          clr,
  input logic          dout,
  input logic          frameWr,
  input logic [AW-1:0] frameAddr,
  input logic          start
);

  logic [AW:0] wrCount;

  always_ff @(posedge clk) begin
    if (clr) wrCount <= '0;
    else if (frameWr) wrCount <= wrCount + (AW+1)'(1);
  end

  // R1: clear drops the outputs
  assert_clear_R1: assert property (@(posedge clk) clr |=> (!start && !frameWr));

  // R5: a frame write follows load bits, so dout is high
  assert_load_high_R5: assert property (@(posedge clk) disable iff (clr)
    frameWr |-> dout);

  // R6: frame addresses in order, never more than NUM_FRAMES writes
  assert_addr_order_R6: assert property (@(posedge clk) disable iff (clr)
    frameWr |-> (frameAddr == AW'(wrCount)));
  assert_frame_limit_R6: assert property (@(posedge clk) disable iff (clr)
    frameWr |-> (wrCount < (AW+1)'(NUM_FRAMES)));

  // R9: start is sticky, silences writes and holds dout high
  assert_start_sticky_R9: assert property (@(posedge clk) disable iff (clr)
    start |=> start);
  assert_no_write_after_start_R9: assert property (@(posedge clk) disable iff (clr)
    start |-> !frameWr);
  assert_done_high_R9: assert property (@(posedge clk) disable iff (clr)
    (start && $past(start)) |-> dout);

endmodule

bind chain_cfg_rx chain_cfg_rx_chk #(
  .FRAME_BITS(FRAME_BITS),
  .NUM_FRAMES(NUM_FRAMES)
) u_chk (
  .clk(clk), .clr(clr), .dout(dout), .frameWr(frameWr),
  .frameAddr(frameAddr), .start(start)
);

// File: tb/chain_cfg_rx_tb.sv
`timescale 1ns/1ps
module chain_cfg_rx_tb;

  localparam int FB = 8;
  localparam int NF = 4;
  localparam int AW = 2;
  localparam int HDR = 36;
  localparam int OWN = FB * NF;

  // idle ones, downstream bits, data seed
  localparam int CASE_TBL [0:4][0:2] = '{
    '{0, 0, 165},
    '{3, 5, 19},
    '{1, 17, 200},
    '{0, 1, 77},
    '{7, 40, 58}
  };

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          din = 1'b1;
  logic          dout, frameWr, start;
  logic [FB-1:0] frameData;
  logic [AW-1:0] frameAddr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic       stream [0:255];
  int         streamLen;
  logic [7:0] frameByte [0:NF-1];

  always #2 clk = ~clk;

  chain_cfg_rx #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) u_dut (
    .clk(clk), .clr(clr), .din(din), .dout(dout), .frameWr(frameWr),
    .frameData(frameData), .frameAddr(frameAddr), .start(start)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic applyClear(string tag);
    @(posedge clk); #1;
    clr = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    clr = 1'b0;
    #2;
    chk({tag, " start after clear"}, 32'(start), 32'd0);
    chk({tag, " frameWr after clear"}, 32'(frameWr), 32'd0);
    chk({tag, " dout after clear"}, 32'(dout), 32'd1);
  endtask

  task automatic buildStream(int idle, int down, int seed);
    logic [11:0] pre = 12'b1111_1111_0010;
    logic [23:0] len = 24'(HDR + OWN + down);
    int pos = 0;
    for (int i = 0; i < idle; i++) begin stream[pos] = 1'b1; pos++; end
    for (int i = 11; i >= 0; i--) begin stream[pos] = pre[i]; pos++; end
    for (int i = 23; i >= 0; i--) begin stream[pos] = len[i]; pos++; end
    for (int f = 0; f < NF; f++) begin
      frameByte[f] = 8'(seed + f * 59) ^ 8'(f << 4);
      for (int i = FB - 1; i >= 0; i--) begin stream[pos] = frameByte[f][i]; pos++; end
    end
    for (int i = 0; i < down; i++) begin
      stream[pos] = ((seed >> (i % 8)) & 1) != ((i % 3) == 0);
      pos++;
    end
    for (int i = 0; i < 3; i++) begin stream[pos] = 1'b0; pos++; end
    streamLen = pos;
  endtask

  task automatic runStream(int idle, int down, int nBits, string tagOver);
    int p0 = idle + HDR;
    int p1 = p0 + OWN;
    int p2 = p1 + down;
    @(posedge clk); #1;
    din = stream[0];
    for (int k = 0; k < nBits; k++) begin
      bit   expWr;
      logic expDout;
      string tag;
      @(posedge clk); #1;
      expWr = (k >= p0) && (k < p1) && (((k - p0) % FB) == FB - 1);
      chk((tagOver != "") ? tagOver : "R6 frameWr", 32'(frameWr), 32'(expWr));
      if (expWr) begin
        chk("R6 frameData", 32'(frameData), 32'(frameByte[(k - p0) / FB]));
        chk("R6 frameAddr", 32'(frameAddr), 32'((k - p0) / FB));
      end
      chk((tagOver != "") ? tagOver : "R8 start", 32'(start), 32'(k >= p2));
      din = (k + 1 < nBits) ? stream[k + 1] : 1'b1;
      #2;
      if (k < idle + 12)  begin expDout = stream[k]; tag = "R2 R4 dout sync";  end
      else if (k < p0)    begin expDout = stream[k]; tag = "R3 R4 dout length"; end
      else if (k < p1)    begin expDout = 1'b1;      tag = "R5 dout loading";  end
      else if (k < p2)    begin expDout = stream[k]; tag = "R7 dout forward";  end
      else                begin expDout = 1'b1;      tag = "R9 dout after start"; end
      if (tagOver != "") tag = tagOver;
      chk(tag, 32'(dout), 32'(expDout));
    end
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    applyClear("R1");

    // table of streams: R2, R3, R5, R6, R7, R8, R9
    for (int c = 0; c < 5; c++) begin
      applyClear("R1");
      buildStream(CASE_TBL[c][0], CASE_TBL[c][1], CASE_TBL[c][2]);
      runStream(CASE_TBL[c][0], CASE_TBL[c][1], streamLen, "");
    end

    // R10: corrupted sync pattern followed by zeros is never captured
    applyClear("R1");
    begin
      logic [11:0] bad = 12'b1111_1111_0011;
      for (int i = 0; i < 12; i++) stream[i] = bad[11 - i];
      for (int i = 12; i < 60; i++) stream[i] = 1'b0;
    end
    runStream(1000, 0, 60, "R10 no capture");

    // R11: clear during the length field, then a full stream
    applyClear("R1");
    buildStream(0, 4, 91);
    runStream(0, 4, 20, "");
    applyClear("R11");
    runStream(0, 4, streamLen, "");

    finishRun();
  end

endmodule